// File: doc/BRIEF.md
# One-Wire Slave Bit-Slot Responder

This block implements the bit-level slave side of a one-wire bus. The raw line is synchronized and watched for falling edges. Each accepted edge starts one internal timer, and that timer paces the whole slot. In a write slot the slave samples the line when the timer reaches a set delay and reports the recovered bit with a one-clock strobe. In a read slot the slave returns the bit presented on `txBit`. A 0 is returned by pulling the line low until the timer expires. A 1 is returned by leaving the line alone.

The surrounding logic selects the slot direction with `readMode` and supplies the bit to send. Both values are captured at the falling edge and held for the rest of the slot. After every slot the line has to stay high for a recovery interval before the slave accepts another edge. A low level that lasts longer than the reset threshold is treated as a bus reset, even if a slot is in progress. Once the line is released after a reset, the slave waits a fixed delay and then drives a presence pulse of fixed length. All intervals are parameters counted in clock cycles. `pullDown` drives an external open-drain transistor, so the bus is the wired AND of the master and this slave.

Top module: `owire_slot_resp`

## Requirements
- R1: After reset, `pullDown`, `rxValid` and `rxBit` are all 0, and the slave stays quiet while the line stays high.
- R2: In a write slot (`readMode`=0 at the falling edge), a line that is back high by the sample point (SAMPLE_CYC cycles after the detected edge) is received as `rxBit`=1.
- R3: In a write slot, a line that is still low at the sample point is received as `rxBit`=0.
- R4: `rxValid` rises once for each write slot and stays high for exactly one clock. It never rises for a read slot.
- R5: In a read slot with `txBit`=0, `pullDown` goes high within a few cycles of the edge and stays high for HOLD_CYC cycles (±1).
- R6: In a read slot with `txBit`=1, `pullDown` stays 0 for the whole slot.
- R7: `txBit` and `readMode` are captured at the falling edge. Changing them later in the slot does not change that slot's behaviour.
- R8: A falling edge that arrives before the line has been high for RECOV_CYC cycles after a slot is ignored. It produces no `rxValid` and no drive. Edges that come well after the recovery interval are accepted.
- R9: A low level longer than RESET_CYC cycles is a reset. About PDELAY_CYC cycles after the line is released, `pullDown` goes high for PRES_CYC cycles (±1) as a presence pulse.
- R10: A reset overrides a slot in progress, including a read-zero slot. The presence pulse still follows, and normal slots work again afterwards.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rstN | input | 1 | Active-low asynchronous reset |
| lineIn | input | 1 | Raw bus line level (asynchronous) |
| pullDown | output | 1 | Enable for the external open-drain pull-down |
| txBit | input | 1 | Bit to return in the next read slot |
| readMode | input | 1 | 1 = next slot is a read slot, 0 = write slot |
| rxBit | output | 1 | Last bit received in a write slot |
| rxValid | output | 1 | One-clock strobe marking a new `rxBit` |

## Verification
The edge that ends the recovery lockout and the master's next falling edge can land in the same cycle. In that case the block must either accept the edge or swallow it as part of the lockout. The bench sweeps the gap between the release of a write-zero slot and the next master low across the recovery boundary. At each offset it counts the resulting `rxValid` strobes. Short gaps must be rejected and long gaps accepted. Acceptance must also be monotonic: once an offset is accepted, every larger offset must be accepted too.

// File: rtl/owire_slot_pkg.sv
package owire_slot_pkg;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_SLOT,
    ST_RECOV,
    ST_RSTWAIT,
    ST_PDELAY,
    ST_PRES
  } slotState_e;

  // strobes from control to datapath
  typedef struct packed {
    logic timerClr;
    logic capTx;
    logic sample;
    logic drvLow;
  } slotStrobe_t;

endpackage

// File: rtl/owire_slot_dp.sv
module owire_slot_dp
  import owire_slot_pkg::*;
#(
  parameter int SYNC_STAGES = 2,
  parameter int TMR_W       = 16,
  parameter int RESET_CYC   = 20000
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             lineIn,
  input  logic             txBit,
  input  logic             readMode,
  input  slotStrobe_t      strb,
  output logic             fallEdge,
  output logic             lineS,
  output logic [TMR_W-1:0] timer,
  output logic             resetHit,
  output logic             txHold,
  output logic             modeHold,
  output logic             pullDown,
  output logic             rxBit,
  output logic             rxValid
);

  localparam logic [TMR_W-1:0] RESET_LIM = TMR_W'(RESET_CYC);

  logic [SYNC_STAGES-1:0] syncQ;
  logic                   lineD;
  logic [TMR_W-1:0]       lowCnt;

  // synchronizer, idle level high
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      syncQ <= '1;
      lineD <= 1'b1;
    end else begin
      syncQ <= {syncQ[SYNC_STAGES-2:0], lineIn};
      lineD <= syncQ[SYNC_STAGES-1];
    end
  end

  assign lineS    = syncQ[SYNC_STAGES-1];
  assign fallEdge = lineD & ~lineS;

  // slot timer: cleared by control, saturating
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      timer <= '0;
    end else if (strb.timerClr) begin
      timer <= '0;
    end else if (timer != '1) begin
      timer <= timer + 1'b1;
    end
  end

  // continuous-low length for reset classification
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      lowCnt <= '0;
    end else if (lineS) begin
      lowCnt <= '0;
    end else if (lowCnt != '1) begin
      lowCnt <= lowCnt + 1'b1;
    end
  end

  assign resetHit = (lowCnt >= RESET_LIM);

  // per-slot capture of direction and transmit bit
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      txHold   <= 1'b1;
      modeHold <= 1'b0;
    end else if (strb.capTx) begin
      txHold   <= txBit;
      modeHold <= readMode;
    end
  end

  // outputs
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      rxBit    <= 1'b0;
      rxValid  <= 1'b0;
      pullDown <= 1'b0;
    end else begin
      rxValid  <= strb.sample;
      pullDown <= strb.drvLow;
      if (strb.sample) begin
        rxBit <= lineS;
      end
    end
  end

endmodule

// File: rtl/owire_slot_ctrl.sv
module owire_slot_ctrl
  import owire_slot_pkg::*;
#(
  parameter int TMR_W      = 16,
  parameter int SAMPLE_CYC = 1500,
  parameter int HOLD_CYC   = 1500,
  parameter int PDELAY_CYC = 1500,
  parameter int PRES_CYC   = 6000,
  parameter int RECOV_CYC  = 250
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             fallEdge,
  input  logic             lineS,
  input  logic [TMR_W-1:0] timer,
  input  logic             resetHit,
  input  logic             txHold,
  input  logic             modeHold,
  output slotStrobe_t      strb,
  output slotState_e       stateOut
);

  localparam logic [TMR_W-1:0] SAMPLE_LIM = TMR_W'(SAMPLE_CYC);
  localparam logic [TMR_W-1:0] HOLD_LIM   = TMR_W'(HOLD_CYC);
  localparam logic [TMR_W-1:0] PDELAY_LIM = TMR_W'(PDELAY_CYC);
  localparam logic [TMR_W-1:0] PRES_LIM   = TMR_W'(PRES_CYC);
  localparam logic [TMR_W-1:0] RECOV_LIM  = TMR_W'(RECOV_CYC);

  slotState_e stateQ, stateNxt;
  logic [TMR_W-1:0] slotEnd;

  assign slotEnd = modeHold ? HOLD_LIM : SAMPLE_LIM;

  always_comb begin
    stateNxt = stateQ;
    strb     = '0;
    if (resetHit && stateQ != ST_RSTWAIT) begin
      stateNxt = ST_RSTWAIT;
    end else begin
      unique case (stateQ)
        ST_IDLE: begin
          if (fallEdge) begin
            stateNxt      = ST_SLOT;
            strb.timerClr = 1'b1;
            strb.capTx    = 1'b1;
          end
        end
        ST_SLOT: begin
          if (timer == slotEnd) begin
            stateNxt      = ST_RECOV;
            strb.timerClr = 1'b1;
            strb.sample   = ~modeHold;
          end
        end
        ST_RECOV: begin
          if (!lineS) begin
            strb.timerClr = 1'b1;
          end else if (timer >= RECOV_LIM) begin
            stateNxt = ST_IDLE;
          end
        end
        ST_RSTWAIT: begin
          if (lineS) begin
            stateNxt      = ST_PDELAY;
            strb.timerClr = 1'b1;
          end
        end
        ST_PDELAY: begin
          if (timer == PDELAY_LIM) begin
            stateNxt      = ST_PRES;
            strb.timerClr = 1'b1;
          end
        end
        ST_PRES: begin
          if (timer == PRES_LIM) begin
            stateNxt      = ST_RECOV;
            strb.timerClr = 1'b1;
          end
        end
        default: stateNxt = ST_IDLE;
      endcase
    end
    strb.drvLow = (stateQ == ST_SLOT && stateNxt == ST_SLOT && modeHold && !txHold)
                || (stateNxt == ST_PRES);
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      stateQ <= ST_IDLE;
    end else begin
      stateQ <= stateNxt;
    end
  end

  assign stateOut = stateQ;

endmodule

// File: rtl/owire_slot_resp.sv
module owire_slot_resp
  import owire_slot_pkg::*;
#(
  parameter int SYNC_STAGES = 2,
  parameter int SAMPLE_CYC  = 1500,
  parameter int HOLD_CYC    = 1500,
  parameter int RESET_CYC   = 20000,
  parameter int PDELAY_CYC  = 1500,
  parameter int PRES_CYC    = 6000,
  parameter int RECOV_CYC   = 250
) (
  input  logic clk,
  input  logic rstN,
  input  logic lineIn,
  output logic pullDown,
  input  logic txBit,
  input  logic readMode,
  output logic rxBit,
  output logic rxValid
);

  localparam int MAX_A   = (SAMPLE_CYC > HOLD_CYC) ? SAMPLE_CYC : HOLD_CYC;
  localparam int MAX_B   = (RESET_CYC > PRES_CYC) ? RESET_CYC : PRES_CYC;
  localparam int MAX_C   = (PDELAY_CYC > RECOV_CYC) ? PDELAY_CYC : RECOV_CYC;
  localparam int MAX_AB  = (MAX_A > MAX_B) ? MAX_A : MAX_B;
  localparam int MAX_ALL = (MAX_AB > MAX_C) ? MAX_AB : MAX_C;
  localparam int TMR_W   = $clog2(MAX_ALL + 2);

  slotStrobe_t      strb;
  slotState_e       stateQ;
  logic             fallEdge, lineS, resetHit, txHold, modeHold;
  logic [TMR_W-1:0] timer;

  owire_slot_ctrl #(
    .TMR_W(TMR_W), .SAMPLE_CYC(SAMPLE_CYC), .HOLD_CYC(HOLD_CYC),
    .PDELAY_CYC(PDELAY_CYC), .PRES_CYC(PRES_CYC), .RECOV_CYC(RECOV_CYC)
  ) ctrl_i (
    .clk(clk), .rstN(rstN), .fallEdge(fallEdge), .lineS(lineS), .timer(timer),
    .resetHit(resetHit), .txHold(txHold), .modeHold(modeHold),
    .strb(strb), .stateOut(stateQ)
  );

  owire_slot_dp #(
    .SYNC_STAGES(SYNC_STAGES), .TMR_W(TMR_W), .RESET_CYC(RESET_CYC)
  ) dp_i (
    .clk(clk), .rstN(rstN), .lineIn(lineIn), .txBit(txBit), .readMode(readMode),
    .strb(strb), .fallEdge(fallEdge), .lineS(lineS), .timer(timer),
    .resetHit(resetHit), .txHold(txHold), .modeHold(modeHold),
    .pullDown(pullDown), .rxBit(rxBit), .rxValid(rxValid)
  );

endmodule

// File: rtl/owire_slot_chk.sv
module owire_slot_chk
  import owire_slot_pkg::*;
(
  input logic       clk,
  input logic       rstN,
  input logic       pullDown,
  input logic       rxValid,
  input logic       fallEdge,
  input logic       resetHit,
  input logic       txHold,
  input logic       modeHold,
  input slotState_e stateQ
);

  assert_idle_quiet_R1: assert property (@(posedge clk) disable iff (!rstN)
    stateQ == ST_IDLE |-> !pullDown);

  assert_rx_pulse_R4: assert property (@(posedge clk) disable iff (!rstN)
    rxValid |=> !rxValid);

  assert_no_rx_in_read_R4: assert property (@(posedge clk) disable iff (!rstN)
    rxValid |-> !modeHold);

  assert_drive_gate_R6: assert property (@(posedge clk) disable iff (!rstN)
    (pullDown && stateQ == ST_SLOT) |-> (modeHold && !txHold));

  assert_capture_stable_R7: assert property (@(posedge clk) disable iff (!rstN)
    (stateQ == ST_SLOT && $past(stateQ) == ST_SLOT) |-> ($stable(txHold) && $stable(modeHold)));

  assert_lockout_R8: assert property (@(posedge clk) disable iff (!rstN)
    (stateQ == ST_RECOV && fallEdge) |=> stateQ != ST_SLOT);

  assert_reset_override_R9: assert property (@(posedge clk) disable iff (!rstN)
    (resetHit && stateQ != ST_RSTWAIT) |=> stateQ == ST_RSTWAIT);

endmodule

bind owire_slot_resp owire_slot_chk chk_i (
  .clk(clk), .rstN(rstN), .pullDown(pullDown), .rxValid(rxValid),
  .fallEdge(fallEdge), .resetHit(resetHit), .txHold(txHold),
  .modeHold(modeHold), .stateQ(stateQ)
);

// File: tb/owire_slot_resp_tb.sv
module owire_slot_resp_tb_top;

  localparam int SAMPLE = 30;
  localparam int HOLD   = 30;
  localparam int RSTLEN = 400;
  localparam int PDLY   = 30;
  localparam int PLEN   = 120;
  localparam int RECOV  = 20;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic mLow = 1'b0;
  logic txBit = 1'b1;
  logic readMode = 1'b0;
  logic lineIn, pullDown, rxBit, rxValid;

  int checks = 0;
  int errors = 0;
  bit finished = 1'b0;

  // bus monitor state
  int vCnt = 0, vRun = 0, vMax = 0;
  logic lastBit = 1'b0;
  int pdRise = 0, pdRun = 0, pdLastW = 0;
  logic pdPrev = 1'b0;

  assign lineIn = ~(mLow | pullDown);

  always #10ns clk = ~clk;

  owire_slot_resp #(
    .SYNC_STAGES(2), .SAMPLE_CYC(SAMPLE), .HOLD_CYC(HOLD), .RESET_CYC(RSTLEN),
    .PDELAY_CYC(PDLY), .PRES_CYC(PLEN), .RECOV_CYC(RECOV)
  ) dut_i (
    .clk(clk), .rstN(rstN), .lineIn(lineIn), .pullDown(pullDown),
    .txBit(txBit), .readMode(readMode), .rxBit(rxBit), .rxValid(rxValid)
  );

  always @(negedge clk) begin
    if (rxValid) begin
      vCnt++;
      lastBit = rxBit;
      vRun++;
      if (vRun > vMax) vMax = vRun;
    end else begin
      vRun = 0;
    end
    if (pullDown) begin
      if (!pdPrev) pdRise++;
      pdRun++;
    end else if (pdPrev) begin
      pdLastW = pdRun;
      pdRun = 0;
    end
    pdPrev = pullDown;
  end

  task automatic chk(input bit ok, input string req, input string what,
                     input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s: actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  task automatic waitCyc(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic clearMon();
    vCnt = 0; vMax = 0; pdRise = 0; pdLastW = 0;
  endtask

  task automatic testReset();
    waitCyc(5);
    chk(pullDown == 1'b0, "R1", "pullDown in reset", int'(pullDown), 0);
    chk(rxValid == 1'b0, "R1", "rxValid in reset", int'(rxValid), 0);
    rstN = 1'b1;
    waitCyc(50);
    chk(rxBit == 1'b0, "R1", "rxBit after reset", int'(rxBit), 0);
    chk(vCnt == 0 && pdRise == 0, "R1", "quiet on idle line", vCnt + pdRise, 0);
  endtask

  task automatic testWrite(input logic b, input bit flipMode);
    clearMon();
    readMode = 1'b0;
    mLow = 1'b1;
    waitCyc(4);
    if (flipMode) begin
      readMode = 1'b1;
      txBit = 1'b0;
    end
    waitCyc(b ? 2 : 56);
    mLow = 1'b0;
    waitCyc(80);
    readMode = 1'b0;
    txBit = 1'b1;
    chk(vCnt == 1, "R4", "rxValid count per write slot", vCnt, 1);
    chk(vMax == 1, "R4", "rxValid width", vMax, 1);
    chk(lastBit == b, b ? "R2" : "R3", "received bit", int'(lastBit), int'(b));
    if (flipMode)
      chk(pdRise == 0, "R7", "no drive after mode change mid-slot", pdRise, 0);
  endtask

  task automatic testRead(input logic b);
    clearMon();
    readMode = 1'b1;
    txBit = b;
    mLow = 1'b1;
    waitCyc(6);
    mLow = 1'b0;
    txBit = ~b;
    readMode = 1'b0;
    waitCyc(80);
    txBit = 1'b1;
    chk(vCnt == 0, "R4", "no rxValid in read slot", vCnt, 0);
    if (b) begin
      chk(pdRise == 0, "R6", "no drive for a one", pdRise, 0);
    end else begin
      chk(pdRise == 1, "R5", "one drive pulse for a zero", pdRise, 1);
      chk(pdLastW >= HOLD - 1 && pdLastW <= HOLD + 1, "R5", "zero hold width", pdLastW, HOLD);
      chk(pdRise == 1, "R7", "drive kept after txBit change", pdRise, 1);
    end
  endtask

  task automatic testLockout();
    bit prevAcc = 1'b0;
    for (int k = 1; k <= 40; k++) begin
      bit acc;
      clearMon();
      readMode = 1'b0;
      mLow = 1'b1;
      waitCyc(60);
      mLow = 1'b0;
      waitCyc(k);
      mLow = 1'b1;
      waitCyc(6);
      mLow = 1'b0;
      waitCyc(100);
      acc = (vCnt == 2);
      chk(vCnt == 1 || vCnt == 2, "R8", "strobe count in sweep", vCnt, 2);
      if (k <= 10) chk(!acc, "R8", "early edge rejected", vCnt, 1);
      if (k >= 32) chk(acc, "R8", "late edge accepted", vCnt, 2);
      chk(!(prevAcc && !acc), "R8", "acceptance monotonic", k, 0);
      chk(pdRise == 0, "R8", "no drive in sweep", pdRise, 0);
      prevAcc = acc;
    end
  endtask

  task automatic testBusReset(input bit readZero, input string req);
    int d;
    clearMon();
    readMode = readZero;
    txBit = ~readZero;
    mLow = 1'b1;
    waitCyc(RSTLEN + 60);
    mLow = 1'b0;
    readMode = 1'b0;
    txBit = 1'b1;
    d = 0;
    while (!pullDown && d < 1000) begin
      @(negedge clk);
      d++;
    end
    chk(d >= PDLY && d <= PDLY + 8, req, "presence delay", d, PDLY);
    waitCyc(PLEN + 150);
    chk(pdLastW >= PLEN - 1 && pdLastW <= PLEN + 2, req, "presence width", pdLastW, PLEN);
  endtask

  initial begin
    testReset();
    testWrite(1'b1, 1'b0);
    testWrite(1'b0, 1'b0);
    testWrite(1'b1, 1'b1);
    testRead(1'b0);
    testRead(1'b1);
    testRead(1'b0);
    testLockout();
    testBusReset(1'b0, "R9");
    testBusReset(1'b1, "R10");
    testWrite(1'b0, 1'b0);
    chk(lastBit == 1'b0, "R10", "slot works after reset", int'(lastBit), 0);
    if (!finished) begin
      finished = 1'b1;
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    #(20ns * 200000);
    if (!finished) begin
      finished = 1'b1;
      checks++;
      errors++;
      $display("FAIL watchdog: actual=timeout expected=completion");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

endmodule